// File: doc/BRIEF.md
# Sliding-Window Modular Exponentiation Sequencer

This block computes Y = X^E mod M. It does not multiply anything itself. It drives an external Montgomery multiplier one command at a time. Each command names two operand slots and a destination slot in the multiplier's operand store. The block then waits for the multiplier's completion pulse before it issues the next command.

A run has three stages:
- **Setup.** The block moves X into the Montgomery domain, creates the Montgomery form of 1 in the accumulator, squares the converted base, and fills a table of the odd powers X^1, X^3, ..., X^(2^WIN - 1).
- **Exponent scan.** While the setup runs, a bit-serial encoder walks the exponent from its highest set bit down to bit 0, one bit per clock. It writes window digits into a small digit memory. The sequencer then replays those digits as squarings and table multiplies on the accumulator.
- **Conversion out.** A final multiply by plain 1 takes the result out of the Montgomery domain.

The exponent must stay stable while `busy` is high.

Top module: `modexp_window_sequencer`

## Requirements
- R1: After reset, `busy`, `done` and `mm_start` are low, and no command is issued until `start` is seen.
- R2: When `start` is sampled high while idle, `busy` rises and the first command is presented with `mm_start` high in the next cycle.
- R3: The setup commands come first, in this order (slot k, for k below 2^(WIN-1), holds X^(2k+1) in Montgomery form):
  - (a=X, b=RR → slot 0)
  - (a=ONE, b=RR → ACC)
  - (a=slot 0, b=slot 0 → SQ)
  - then (a=slot k-1, b=SQ → slot k) for k = 1 up to 2^(WIN-1)-1.
  - The special slots sit above the table at offsets +0 X, +1 RR, +2 ONE, +3 SQ, +4 ACC, +5 OUT.
- R4: The encoder looks at one exponent bit per clock. It skips bits above the highest set bit. It stores WIN-bit digits in scan order:
  - a digit of 0 stands for one zero bit;
  - a nonzero digit is an odd window value, and its length is the position of its top set bit plus one.
- R5: Each zero exponent bit produces exactly one squaring command (a=ACC, b=ACC → ACC).
- R6: At a one bit, the window is the longest string of at most WIN bits starting there that ends in a 1. For that window the sequencer issues:
  - one squaring per window bit;
  - then one command (a=slot (v-1)/2, b=ACC → ACC);
  - then it resumes at the bit below the window.
- R7: The last command is (a=ONE, b=ACC → OUT). `done` is high for exactly one cycle, one cycle after that command's `mm_done` is sampled, and `busy` is low in that cycle.
- R8: With a correct multiplier, the OUT slot holds X^E mod M when `done` pulses.
- R9: For top set bit t, the command count equals 19 + (t+1) + (number of windows), and never exceeds t + ceil((t+1)/5) + 20 for WIN=5.
- R10: An exponent of zero gives exactly 19 commands (setup plus conversion out) and a result of 1.
- R11: `start` pulses while busy have no effect on the command stream or the result.
- R12: At most one command is outstanding. `mm_start` is a single-cycle pulse and is not raised again until `mm_done` has been sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an exponentiation (accepted only when idle) |
| exp_value | input | EXP_W | Exponent E, held stable while busy |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |
| mm_start | output | 1 | Multiplier command strobe |
| mm_src_a | output | ADDR_W | First operand slot |
| mm_src_b | output | ADDR_W | Second operand slot |
| mm_dst | output | ADDR_W | Destination slot |
| mm_done | input | 1 | Multiplier completion pulse |

## Verification
The first command strobe is due in the cycle right after `start` is sampled. The `done` pulse is due exactly one cycle after the final `mm_done` is sampled.

The bench drives and samples everything on falling edges and numbers those edges. It records the edge where the multiplier model raised its last completion and the edge where `done` was first seen, and it requires them to differ by exactly one. Every command is logged and compared, position by position, with a list built from a software window scan. The multiplier model's latency is varied so that command timing never depends on a fixed delay.

// File: rtl/mxw_pkg.sv
package mxw_pkg;

  // Phases of the command stream
  typedef enum logic [2:0] {
    PH_X1,
    PH_CR,
    PH_X2,
    PH_TAB,
    PH_SCAN,
    PH_OUT
  } phase_e;

  // Sequencer control states
  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_ISSUE,
    SQ_WAIT,
    SQ_FETCH,
    SQ_DONE
  } seq_state_e;

  // Encoder control states
  typedef enum logic [2:0] {
    EN_IDLE,
    EN_SEEK,
    EN_SCAN,
    EN_GATHER,
    EN_FIN
  } enc_state_e;

endpackage

// File: rtl/mxw_exp_encoder.sv
module mxw_exp_encoder
  import mxw_pkg::*;
#(
  parameter int EXP_W = 64,
  parameter int WIN   = 5,
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [EXP_W-1:0] exp_value,
  output logic             wr_en,
  output logic [CNT_W-1:0] wr_ptr,
  output logic [WIN-1:0]   wr_data,
  output logic             fin
);

  localparam int IDX_W = (EXP_W > 1) ? $clog2(EXP_W) : 1;
  localparam int LEN_W = $clog2(WIN + 1);

  enc_state_e        st_q, st_d;
  logic [CNT_W-1:0]  left_q, left_d;
  logic [CNT_W-1:0]  base_q, base_d;
  logic [WIN-1:0]    win_q, win_d;
  logic [LEN_W-1:0]  len_q, len_d;
  logic [LEN_W-1:0]  last_q, last_d;
  logic [CNT_W-1:0]  ptr_q, ptr_d;
  logic              cur_bit;
  logic [LEN_W-1:0]  trail;

  assign cur_bit = exp_value[IDX_W'(left_q - CNT_W'(1))];
  assign trail   = len_q - last_q;

  always_comb begin
    st_d    = st_q;
    left_d  = left_q;
    base_d  = base_q;
    win_d   = win_q;
    len_d   = len_q;
    last_d  = last_q;
    ptr_d   = ptr_q;
    wr_en   = 1'b0;
    wr_data = '0;
    case (st_q)
      EN_SEEK, EN_SCAN: begin
        if (left_q == '0) begin
          st_d = EN_FIN;
        end else begin
          left_d = left_q - CNT_W'(1);
          if (cur_bit) begin
            win_d  = WIN'(1);
            len_d  = LEN_W'(1);
            last_d = LEN_W'(1);
            base_d = left_q;
            st_d   = EN_GATHER;
          end else if (st_q == EN_SCAN) begin
            wr_en = 1'b1;
          end
        end
      end
      EN_GATHER: begin
        if (len_q == LEN_W'(WIN) || left_q == '0) begin
          wr_en   = 1'b1;
          wr_data = win_q >> trail;
          left_d  = base_q - CNT_W'(last_q);
          st_d    = EN_SCAN;
        end else begin
          win_d  = {win_q[WIN-2:0], cur_bit};
          len_d  = len_q + LEN_W'(1);
          left_d = left_q - CNT_W'(1);
          if (cur_bit) last_d = len_q + LEN_W'(1);
        end
      end
      default: ;
    endcase
    if (wr_en) ptr_d = ptr_q + CNT_W'(1);
    if (go) begin
      st_d   = EN_SEEK;
      left_d = CNT_W'(EXP_W);
      ptr_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= EN_IDLE;
      left_q <= '0;
      base_q <= '0;
      win_q  <= '0;
      len_q  <= '0;
      last_q <= '0;
      ptr_q  <= '0;
    end else begin
      st_q   <= st_d;
      left_q <= left_d;
      base_q <= base_d;
      win_q  <= win_d;
      len_q  <= len_d;
      last_q <= last_d;
      ptr_q  <= ptr_d;
    end
  end

  assign wr_ptr = ptr_q;
  assign fin    = (st_q == EN_FIN);

  // Every nonzero digit is an odd window value (R4)
  assert_window_odd_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data != '0) |-> wr_data[0]);

  // Digit memory never written past its depth (R4)
  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (ptr_q < CNT_W'(EXP_W)));

endmodule

// File: rtl/mxw_digit_mem.sv
module mxw_digit_mem #(
  parameter int WIDTH = 5,
  parameter int DEPTH = 64,
  parameter int AW    = 6
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [AW-1:0]    rd_addr,
  output logic [WIDTH-1:0] rd_data
);

  logic [WIDTH-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[wr_addr] <= wr_data;
  end

  assign rd_data = mem_q[rd_addr];

endmodule

// File: rtl/mxw_cmd_sequencer.sv
module mxw_cmd_sequencer
  import mxw_pkg::*;
#(
  parameter int EXP_W  = 64,
  parameter int WIN    = 5,
  parameter int ADDR_W = 5,
  parameter int CNT_W  = 7,
  parameter int MEM_AW = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic              enc_go,
  input  logic              enc_fin,
  input  logic [CNT_W-1:0]  enc_count,
  output logic [MEM_AW-1:0] rd_addr,
  input  logic [WIN-1:0]    rd_data,
  output logic              mm_start,
  output logic [ADDR_W-1:0] mm_src_a,
  output logic [ADDR_W-1:0] mm_src_b,
  output logic [ADDR_W-1:0] mm_dst,
  input  logic              mm_done
);

  localparam int TAB_N = 1 << (WIN - 1);
  localparam int TW    = (WIN > 1) ? WIN - 1 : 1;
  localparam int SQ_W  = $clog2(WIN + 1);
  localparam logic [ADDR_W-1:0] ADR_X   = ADDR_W'(TAB_N);
  localparam logic [ADDR_W-1:0] ADR_RR  = ADDR_W'(TAB_N + 1);
  localparam logic [ADDR_W-1:0] ADR_ONE = ADDR_W'(TAB_N + 2);
  localparam logic [ADDR_W-1:0] ADR_SQ  = ADDR_W'(TAB_N + 3);
  localparam logic [ADDR_W-1:0] ADR_ACC = ADDR_W'(TAB_N + 4);
  localparam logic [ADDR_W-1:0] ADR_OUT = ADDR_W'(TAB_N + 5);
  localparam int BOUND = (EXP_W - 1) + (EXP_W + WIN - 1) / WIN + 20;
  localparam int BW    = $clog2(BOUND + 2);

  function automatic logic [SQ_W-1:0] win_len(input logic [WIN-1:0] v);
    win_len = '0;
    for (int b = 0; b < WIN; b++) if (v[b]) win_len = SQ_W'(b + 1);
  endfunction

  seq_state_e        state_q, state_d;
  phase_e            phase_q, phase_d;
  logic [TW-1:0]     tab_q, tab_d;
  logic [SQ_W-1:0]   sq_q, sq_d;
  logic              mul_q, mul_d;
  logic [TW-1:0]     slot_q, slot_d;
  logic [CNT_W-1:0]  rd_ptr_q, rd_ptr_d;
  logic [ADDR_W-1:0] a_q, a_d, b_q, b_d, d_q, d_d;

  always_comb begin
    state_d  = state_q;
    phase_d  = phase_q;
    tab_d    = tab_q;
    sq_d     = sq_q;
    mul_d    = mul_q;
    slot_d   = slot_q;
    rd_ptr_d = rd_ptr_q;
    a_d      = a_q;
    b_d      = b_q;
    d_d      = d_q;
    enc_go   = 1'b0;
    case (state_q)
      SQ_IDLE: if (start) begin
        enc_go   = 1'b1;
        rd_ptr_d = '0;
        phase_d  = PH_X1;
        {a_d, b_d, d_d} = {ADR_X, ADR_RR, ADDR_W'(0)};
        state_d  = SQ_ISSUE;
      end
      SQ_ISSUE: state_d = SQ_WAIT;
      SQ_WAIT: if (mm_done) begin
        state_d = SQ_ISSUE;
        case (phase_q)
          PH_X1: begin
            phase_d = PH_CR;
            {a_d, b_d, d_d} = {ADR_ONE, ADR_RR, ADR_ACC};
          end
          PH_CR: begin
            phase_d = PH_X2;
            {a_d, b_d, d_d} = {ADDR_W'(0), ADDR_W'(0), ADR_SQ};
          end
          PH_X2: begin
            phase_d = PH_TAB;
            tab_d   = TW'(1);
            {a_d, b_d, d_d} = {ADDR_W'(0), ADR_SQ, ADDR_W'(1)};
          end
          PH_TAB: begin
            if (tab_q == TW'(TAB_N - 1)) begin
              phase_d = PH_SCAN;
              state_d = SQ_FETCH;
            end else begin
              tab_d = tab_q + TW'(1);
              {a_d, b_d, d_d} = {ADDR_W'(tab_q), ADR_SQ, ADDR_W'(tab_d)};
            end
          end
          PH_SCAN: begin
            if (sq_q != '0) begin
              sq_d = sq_q - SQ_W'(1);
              {a_d, b_d, d_d} = {ADR_ACC, ADR_ACC, ADR_ACC};
            end else if (mul_q) begin
              mul_d = 1'b0;
              {a_d, b_d, d_d} = {ADDR_W'(slot_q), ADR_ACC, ADR_ACC};
            end else begin
              state_d = SQ_FETCH;
            end
          end
          default: state_d = SQ_DONE;
        endcase
      end
      SQ_FETCH: begin
        if (rd_ptr_q < enc_count) begin
          rd_ptr_d = rd_ptr_q + CNT_W'(1);
          {a_d, b_d, d_d} = {ADR_ACC, ADR_ACC, ADR_ACC};
          if (rd_data == '0) begin
            sq_d  = '0;
            mul_d = 1'b0;
          end else begin
            sq_d   = win_len(rd_data) - SQ_W'(1);
            mul_d  = 1'b1;
            slot_d = TW'(rd_data >> 1);
          end
          state_d = SQ_ISSUE;
        end else if (enc_fin) begin
          phase_d = PH_OUT;
          {a_d, b_d, d_d} = {ADR_ONE, ADR_ACC, ADR_OUT};
          state_d = SQ_ISSUE;
        end
      end
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= SQ_IDLE;
      phase_q  <= PH_X1;
      tab_q    <= '0;
      sq_q     <= '0;
      mul_q    <= 1'b0;
      slot_q   <= '0;
      rd_ptr_q <= '0;
      a_q      <= '0;
      b_q      <= '0;
      d_q      <= '0;
    end else begin
      state_q  <= state_d;
      phase_q  <= phase_d;
      tab_q    <= tab_d;
      sq_q     <= sq_d;
      mul_q    <= mul_d;
      slot_q   <= slot_d;
      rd_ptr_q <= rd_ptr_d;
      a_q      <= a_d;
      b_q      <= b_d;
      d_q      <= d_d;
    end
  end

  assign busy     = (state_q != SQ_IDLE) && (state_q != SQ_DONE);
  assign done     = (state_q == SQ_DONE);
  assign mm_start = (state_q == SQ_ISSUE);
  assign mm_src_a = a_q;
  assign mm_src_b = b_q;
  assign mm_dst   = d_q;
  assign rd_addr  = rd_ptr_q[MEM_AW-1:0];

  // Command counter kept only for the bound check
  logic [BW-1:0] issued_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         issued_q <= '0;
    else if (state_q == SQ_IDLE && start) issued_q <= '0;
    else if (mm_start)                  issued_q <= issued_q + BW'(1);
  end

  assert_cmd_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    issued_q <= BW'(BOUND));

  assert_single_strobe_R12: assert property (@(posedge clk) disable iff (!rst_n)
    mm_start |=> !mm_start);

  assert_wait_for_done_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SQ_WAIT && !mm_done) |=> !mm_start);

  assert_scan_to_acc_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mm_start && phase_q == PH_SCAN) |-> (mm_dst == ADR_ACC));

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_read_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ptr_q <= enc_count);

endmodule

// File: rtl/modexp_window_sequencer.sv
module modexp_window_sequencer
  import mxw_pkg::*;
#(
  parameter int EXP_W  = 64,
  parameter int WIN    = 5,
  parameter int ADDR_W = $clog2((1 << (WIN - 1)) + 6)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [EXP_W-1:0]  exp_value,
  output logic              busy,
  output logic              done,
  output logic              mm_start,
  output logic [ADDR_W-1:0] mm_src_a,
  output logic [ADDR_W-1:0] mm_src_b,
  output logic [ADDR_W-1:0] mm_dst,
  input  logic              mm_done
);

  localparam int CNT_W  = $clog2(EXP_W + 1);
  localparam int MEM_AW = (EXP_W > 1) ? $clog2(EXP_W) : 1;

  logic              enc_go;
  logic              enc_fin;
  logic              wr_en;
  logic [CNT_W-1:0]  wr_ptr;
  logic [WIN-1:0]    wr_data;
  logic [MEM_AW-1:0] rd_addr;
  logic [WIN-1:0]    rd_data;

  mxw_exp_encoder #(.EXP_W(EXP_W), .WIN(WIN), .CNT_W(CNT_W)) encoder_i (
    .clk(clk), .rst_n(rst_n), .go(enc_go), .exp_value(exp_value),
    .wr_en(wr_en), .wr_ptr(wr_ptr), .wr_data(wr_data), .fin(enc_fin)
  );

  mxw_digit_mem #(.WIDTH(WIN), .DEPTH(EXP_W), .AW(MEM_AW)) digits_i (
    .clk(clk), .wr_en(wr_en), .wr_addr(wr_ptr[MEM_AW-1:0]), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  mxw_cmd_sequencer #(.EXP_W(EXP_W), .WIN(WIN), .ADDR_W(ADDR_W),
                      .CNT_W(CNT_W), .MEM_AW(MEM_AW)) seq_i (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .enc_go(enc_go), .enc_fin(enc_fin), .enc_count(wr_ptr),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .mm_start(mm_start), .mm_src_a(mm_src_a), .mm_src_b(mm_src_b),
    .mm_dst(mm_dst), .mm_done(mm_done)
  );

endmodule

// File: tb/modexp_window_sequencer_tb_top.sv
`timescale 1ns/1ps
module modexp_window_sequencer_tb_top;

  localparam int EXP_W = 64;
  localparam int AW    = 5;
  localparam int A_X = 16, A_RR = 17, A_ONE = 18, A_SQ = 19, A_ACC = 20, A_OUT = 21;
  localparam int MAXC = 160;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [EXP_W-1:0] exp_value = '0;
  logic busy, done, mm_start, mm_done;
  logic [AW-1:0] mm_src_a, mm_src_b, mm_dst;

  always #4 clk = ~clk;

  modexp_window_sequencer #(.EXP_W(EXP_W), .WIN(5)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .exp_value(exp_value),
    .busy(busy), .done(done), .mm_start(mm_start), .mm_src_a(mm_src_a),
    .mm_src_b(mm_src_b), .mm_dst(mm_dst), .mm_done(mm_done)
  );

  int checks = 0;
  int fails  = 0;
  longint unsigned modm, rinv;
  longint unsigned slot_v [32];
  int lat = 2;
  int pend = 0;
  int pa, pb, pd;
  int neg_n = 0, done_n = -1, last_mmdone_n = -1, proto_err = 0;
  int n_log = 0;
  int log_a [MAXC], log_b [MAXC], log_d [MAXC];
  int n_exp = 0;
  int exp_a [MAXC], exp_b [MAXC], exp_d [MAXC];

  function automatic longint unsigned mmul(longint unsigned a, longint unsigned b);
    return (((a * b) % modm) * rinv) % modm;
  endfunction

  function automatic longint unsigned powmod(longint unsigned x, logic [63:0] e);
    longint unsigned r = 1;
    for (int k = 63; k >= 0; k--) begin
      r = (r * r) % modm;
      if (e[k]) r = (r * x) % modm;
    end
    return r;
  endfunction

  // Behavioural multiplier: samples and drives on falling edges
  initial mm_done = 1'b0;
  always @(negedge clk) begin
    bit was_busy;
    neg_n++;
    was_busy = (pend > 0);
    mm_done = 1'b0;
    if (done) done_n = neg_n;
    if (pend > 0) begin
      pend--;
      if (pend == 0) begin
        slot_v[pd] = mmul(slot_v[pa], slot_v[pb]);
        mm_done = 1'b1;
        last_mmdone_n = neg_n;
      end
    end
    if (mm_start) begin
      if (was_busy) proto_err++;
      if (n_log < MAXC) begin
        log_a[n_log] = int'(mm_src_a);
        log_b[n_log] = int'(mm_src_b);
        log_d[n_log] = int'(mm_dst);
      end
      n_log++;
      pa = int'(mm_src_a); pb = int'(mm_src_b); pd = int'(mm_dst);
      pend = lat;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic push(input int a, input int b, input int d);
    exp_a[n_exp] = a; exp_b[n_exp] = b; exp_d[n_exp] = d;
    n_exp++;
  endtask

  // Software window scan producing the expected command list
  task automatic build_expected(input logic [63:0] e, output int bound);
    int t, i, l;
    int unsigned v;
    n_exp = 0;
    bound = 19;
    push(A_X, A_RR, 0);
    push(A_ONE, A_RR, A_ACC);
    push(0, 0, A_SQ);
    for (int k = 1; k < 16; k++) push(k - 1, A_SQ, k);
    if (e != 0) begin
      t = 63;
      while (!e[t]) t--;
      bound = t + (t + 5) / 5 + 20;
      i = t;
      while (i >= 0) begin
        if (!e[i]) begin
          push(A_ACC, A_ACC, A_ACC);
          i--;
        end else begin
          l = (i - 4 > 0) ? i - 4 : 0;
          while (!e[l]) l++;
          v = 0;
          for (int j = i; j >= l; j--) v = (v << 1) | int'(e[j]);
          for (int j = 0; j <= i - l; j++) push(A_ACC, A_ACC, A_ACC);
          push(int'((v - 1) / 2), A_ACC, A_ACC);
          i = l - 1;
        end
      end
    end
    push(A_ONE, A_ACC, A_OUT);
  endtask

  task automatic setup_mod(input longint unsigned m, input longint unsigned x);
    longint unsigned rmod, h;
    modm = m;
    h = (m + 1) / 2;
    rinv = 1;
    for (int k = 0; k < 32; k++) rinv = (rinv * h) % m;
    rmod = 64'h1_0000_0000 % m;
    for (int k = 0; k < 32; k++) slot_v[k] = 0;
    slot_v[A_X]   = x % m;
    slot_v[A_RR]  = (rmod * rmod) % m;
    slot_v[A_ONE] = 1;
  endtask

  task automatic run_case(input string name, input logic [63:0] e,
                          input longint unsigned m, input longint unsigned x,
                          input int latency, input bit restart);
    int bound, cyc, bad_pre, bad_scan;
    bit got_done;
    longint unsigned want;
    $display("-- scenario %s", name);
    setup_mod(m, x);
    build_expected(e, bound);
    want = powmod(x % m, e);
    lat = latency;
    n_log = 0; proto_err = 0; done_n = -1;
    exp_value = e;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk(mm_start && busy, "R2", "first strobe after start", {mm_start, busy}, 3);
    chk(mm_src_a == AW'(A_X) && mm_dst == '0, "R3", "first command slot a",
        longint'(mm_src_a), A_X);
    got_done = 1'b0;
    cyc = 0;
    while (!got_done && cyc < 20000) begin
      @(negedge clk);
      cyc++;
      if (restart && cyc == 40) start = 1'b1;
      if (restart && cyc == 41) start = 1'b0;
      if (done) got_done = 1'b1;
    end
    #1;
    chk(got_done, "R7", "done reached", got_done, 1);
    if (!got_done) return;
    chk(!busy, "R7", "busy low with done", busy, 0);
    chk(done_n == last_mmdone_n + 1, "R7", "done edge after last mm_done",
        done_n - last_mmdone_n, 1);
    chk(slot_v[A_OUT] == want, (e == 0) ? "R10" : "R8", "result",
        longint'(slot_v[A_OUT]), longint'(want));
    chk(n_log == n_exp, (e == 0) ? "R10" : "R9", "command count", n_log, n_exp);
    chk(n_log <= bound, "R9", "count within bound", n_log, bound);
    bad_pre = 0; bad_scan = 0;
    for (int k = 0; k < n_exp && k < n_log && k < MAXC; k++) begin
      if (log_a[k] != exp_a[k] || log_b[k] != exp_b[k] || log_d[k] != exp_d[k]) begin
        if (k < 18) bad_pre++; else bad_scan++;
      end
    end
    chk(bad_pre == 0, "R3", "setup commands mismatching", bad_pre, 0);
    chk(bad_scan == 0, "R4 R5 R6", "scan commands mismatching", bad_scan, 0);
    if (n_log > 0 && n_log <= MAXC)
      chk(log_a[n_log-1] == A_ONE && log_d[n_log-1] == A_OUT, "R7",
          "final command destination", log_d[n_log-1], A_OUT);
    chk(proto_err == 0, "R12", "strobes while outstanding", proto_err, 0);
    if (restart) chk(n_log == n_exp && slot_v[A_OUT] == want, "R11",
                     "restart pulse ignored", n_log, n_exp);
    repeat (3) @(negedge clk);
  endtask

  task automatic test_reset();
    repeat (3) @(negedge clk);
    chk(!busy && !done && !mm_start, "R1", "idle outputs after reset",
        {busy, done, mm_start}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!busy && !mm_start && n_log == 0, "R1", "no command without start", n_log, 0);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual expired expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin : main
    test_reset();
    run_case("zero exponent", 64'd0, 64'd1000003, 64'd12345, 2, 1'b0);
    run_case("exponent one", 64'd1, 64'd2147483647, 64'd987654321, 1, 1'b0);
    run_case("five-bit window", 64'b10001, 64'd1000003, 64'd777, 3, 1'b0);
    run_case("split window", 64'b100001, 64'd65521, 64'd4242, 2, 1'b0);
    run_case("trailing zeros", 64'b110, 64'd999983, 64'd31337, 1, 1'b0);
    run_case("sparse long", 64'h8000_0000_0000_0001, 64'd2147483647, 64'd5, 2, 1'b0);
    run_case("all ones", 64'hFFFF_FFFF_FFFF_FFFF, 64'd1000000007, 64'd123456789, 1, 1'b0);
    run_case("mixed with restart", 64'hA5C3_0F19_7E24_B6D1, 64'd2147483629, 64'd99991, 4, 1'b1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule